// File: doc/BRIEF.md
# Open-Wire Input Check Controller

This block runs a two-conversion open-wire diagnostic on one analog input of a sigma-delta ADC front end. A start request holds a 5-bit pin code, a 2-bit input-range variant and a settling time in clock cycles. The block then runs these steps in order:

1. It requests a baseline conversion with the excitation current off.
2. It turns the current on for the selected pin and waits out the settling time.
3. It requests a second conversion.
4. It turns the current off and waits out the settling time again, so the channel is ready for normal conversions.
5. It reports the signed code difference and an open flag.

The excitation current scales with the converter reference. Because of this, the decision threshold is a fixed fraction of full scale and no reference value enters the block. To check a differential pair, run the check twice, once for each pin. The block connects to the converter through a start strobe, a done strobe and a signed result. The current source, the attenuator and the modulator are outside the block.

Top module: `owc_ctrl`

## Requirements
- R1: After reset, `busy_o`, `exc_en_o`, `conv_start_o`, `done_o`, `open_o` and `sel_err_o` are 0, `delta_o` is 0 and `exc_sel_o` is 0.
- R2: An accepted check issues exactly two one-cycle `conv_start_o` pulses. The first is issued with `exc_en_o` low. The second is issued with `exc_en_o` high. Each pulse is followed by waiting for `conv_done_i`.
- R3: The second `conv_start_o` comes at least `settle_cycles_i` cycles after `exc_en_o` rises. The value of `settle_cycles_i` is the one sampled at the accepted start.
- R4: After the second conversion completes, `exc_en_o` falls. At least `settle_cycles_i` cycles then pass with `busy_o` high before `done_o`.
- R5: `delta_o` equals the second result minus the baseline, both read as 24-bit two's complement. The difference is saturated to the range -8388608..8388607.
- R6: `open_o` is 1 exactly when `delta_o` > T. T = floor(P × 8388607 / 1000). P is 174 for variant 0 (±12 V range, 17.4 %), 238 for variant 1 (±20 V range, 23.8 %), and 244 for variants 2 and 3 (±40 V range, 24.4 %). A difference equal to T reports connected.
- R7: A start whose pin code has bit 4 set (codes 10000b to 11111b) is rejected. The block issues no conversion, `exc_en_o` stays 0, `busy_o` stays 0 and `exc_sel_o` keeps its value. `sel_err_o` goes high in the next cycle and stays high until a start with a code from 00000b to 01111b is accepted.
- R8: A start request while `busy_o` is high has no effect. The running check keeps its pin code, issues no extra conversion and produces a single `done_o`.
- R9: `abort_i` has priority over every other input. In the next cycle `exc_en_o` and `busy_o` are 0. No `done_o` follows, and `delta_o` and `open_o` keep their previous values.
- R10: `busy_o` rises in the cycle after an accepted start. `done_o` is a one-cycle pulse in the cycle that `busy_o` returns to 0. `delta_o` and `open_o` change only together with `done_o`.
- R11: `exc_sel_o` carries the pin code of the last accepted check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a check |
| abort_i | input | 1 | Synchronous abort |
| pin_sel_i | input | 5 | Pin code to test |
| variant_i | input | 2 | Input-range variant, selects the threshold |
| settle_cycles_i | input | 32 | Settling wait in clock cycles |
| conv_start_o | output | 1 | One-cycle conversion request |
| conv_done_i | input | 1 | Conversion complete strobe |
| conv_data_i | input | 24 | Signed conversion result |
| exc_en_o | output | 1 | Excitation current enable |
| exc_sel_o | output | 5 | Pin the excitation current is routed to |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle result strobe |
| open_o | output | 1 | Pin judged floating |
| delta_o | output | 24 | Saturated signed code difference |
| sel_err_o | output | 1 | Last start had an invalid pin code |

## Verification
The bench builds the block with its default widths: 24-bit data, 5-bit pin codes and a 32-bit settling counter. With these widths, full scale is 8388607. Extreme baseline and second codes can then drive the subtraction past both ends of the range and exercise saturation. Difference values one code on either side of each computed threshold are also reachable. Settling times of 0, 5 and 200 cycles are applied through the port, which covers the zero-length wait and a wait much longer than the conversion latency.

// File: rtl/owc_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the open-wire check controller.
// Assumes a 2-bit variant code; variants beyond the last defined one reuse it.
package owc_pkg;

    localparam int VAR_W   = 2;
    localparam int NUM_VAR = 1 << VAR_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE_REQ,
        ST_BASE_WAIT,
        ST_ON_SETTLE,
        ST_MEAS_REQ,
        ST_MEAS_WAIT,
        ST_OFF_SETTLE
    } owc_state_e;

    // Threshold in tenths of a percent of full scale, per variant.
    function automatic int unsigned permille_of(input int idx);
        case (idx)
            0:       return 174;
            1:       return 238;
            default: return 244;
        endcase
    endfunction

endpackage

// File: rtl/owc_settle_timer.sv
`timescale 1ns/1ps
// Down-counter for the settling wait. It loads a cycle count and decrements
// while run is high. zero_o is high once the count is exhausted.
// Assumes load and run never assert in the same cycle.
module owc_settle_timer #(
    parameter int WAIT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] load_val_i,
    input  logic              run_i,
    output logic              zero_o
);

    logic [WAIT_W-1:0] cnt_q;

    // Load or count down the remaining settling cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/owc_judge.sv
`timescale 1ns/1ps
// Combinational decision path. It forms the saturated difference
// (sample - baseline) and compares it with the per-variant threshold,
// which is derived from full scale at elaboration.
// Assumes both inputs are two's complement codes of DATA_W bits.
module owc_judge
    import owc_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [VAR_W-1:0]  variant_i,
    output logic [DATA_W-1:0] delta_o,
    output logic              open_o
);

    localparam logic [63:0] FS64 = (64'd1 << (DATA_W - 1)) - 64'd1;
    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] thr_tab [NUM_VAR];

    for (genvar g = 0; g < NUM_VAR; g++) begin : g_thr
        localparam logic [63:0] THR64 = (FS64 * 64'(permille_of(g))) / 64'd1000;
        assign thr_tab[g] = THR64[DATA_W-1:0];
    end

    logic [DATA_W:0] wide;

    // Sign-extended subtraction followed by clamping to the result range.
    always_comb begin
        wide = {sample_i[DATA_W-1], sample_i} - {base_i[DATA_W-1], base_i};
        if (wide[DATA_W] != wide[DATA_W-1]) begin
            delta_o = wide[DATA_W] ? NEG_MIN : POS_MAX;
        end else begin
            delta_o = wide[DATA_W-1:0];
        end
    end

    // Strictly-greater comparison against the selected threshold.
    always_comb begin
        open_o = $signed(delta_o) > $signed(thr_tab[variant_i]);
    end

endmodule

// File: rtl/owc_seq.sv
`timescale 1ns/1ps
// Check sequencer. It accepts a start, runs baseline -> excite -> settle ->
// measure -> release -> settle, and publishes the result with a done pulse.
// Assumes conv_done_i arrives some cycles after each conv_start_o pulse;
// strobes seen outside a wait state are ignored.
module owc_seq
    import owc_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int SEL_W  = 5,
    parameter int WAIT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [SEL_W-1:0]  pin_sel_i,
    input  logic [VAR_W-1:0]  variant_i,
    input  logic [WAIT_W-1:0] settle_i,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic              tmr_zero_i,
    input  logic [DATA_W-1:0] jdg_delta_i,
    input  logic              jdg_open_i,
    output logic              tmr_load_o,
    output logic [WAIT_W-1:0] tmr_val_o,
    output logic              tmr_run_o,
    output logic [DATA_W-1:0] base_o,
    output logic [VAR_W-1:0]  variant_o,
    output logic              conv_start_o,
    output logic              exc_en_o,
    output logic [SEL_W-1:0]  exc_sel_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              open_o,
    output logic [DATA_W-1:0] delta_o,
    output logic              sel_err_o
);

    owc_state_e        state_q;
    logic [WAIT_W-1:0] settle_q;
    logic [DATA_W-1:0] pend_delta_q;
    logic              pend_open_q;
    logic              conv_back;

    assign conv_back    = conv_done_i &&
                          ((state_q == ST_BASE_WAIT) || (state_q == ST_MEAS_WAIT));
    assign tmr_load_o   = conv_back && !abort_i;
    assign tmr_val_o    = settle_q;
    assign tmr_run_o    = (state_q == ST_ON_SETTLE) || (state_q == ST_OFF_SETTLE);
    assign conv_start_o = (state_q == ST_BASE_REQ) || (state_q == ST_MEAS_REQ);
    assign busy_o       = (state_q != ST_IDLE);

    // Main state machine with result and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            settle_q     <= '0;
            base_o       <= '0;
            variant_o    <= '0;
            exc_en_o     <= 1'b0;
            exc_sel_o    <= '0;
            done_o       <= 1'b0;
            open_o       <= 1'b0;
            delta_o      <= '0;
            sel_err_o    <= 1'b0;
            pend_delta_q <= '0;
            pend_open_q  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (abort_i) begin
                state_q  <= ST_IDLE;
                exc_en_o <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start_i) begin
                            if (pin_sel_i[SEL_W-1]) begin
                                sel_err_o <= 1'b1;
                            end else begin
                                sel_err_o <= 1'b0;
                                exc_sel_o <= pin_sel_i;
                                variant_o <= variant_i;
                                settle_q  <= settle_i;
                                state_q   <= ST_BASE_REQ;
                            end
                        end
                    end
                    ST_BASE_REQ: state_q <= ST_BASE_WAIT;
                    ST_BASE_WAIT: begin
                        if (conv_done_i) begin
                            base_o   <= conv_data_i;
                            exc_en_o <= 1'b1;
                            state_q  <= ST_ON_SETTLE;
                        end
                    end
                    ST_ON_SETTLE: begin
                        if (tmr_zero_i) state_q <= ST_MEAS_REQ;
                    end
                    ST_MEAS_REQ: state_q <= ST_MEAS_WAIT;
                    ST_MEAS_WAIT: begin
                        if (conv_done_i) begin
                            pend_delta_q <= jdg_delta_i;
                            pend_open_q  <= jdg_open_i;
                            exc_en_o     <= 1'b0;
                            state_q      <= ST_OFF_SETTLE;
                        end
                    end
                    ST_OFF_SETTLE: begin
                        if (tmr_zero_i) begin
                            done_o  <= 1'b1;
                            delta_o <= pend_delta_q;
                            open_o  <= pend_open_q;
                            state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/owc_ctrl.sv
`timescale 1ns/1ps
// Open-wire check controller top. It wires the sequencer, the settling
// timer and the decision path together. Assumes one converter shared with
// normal traffic, which must stay idle while busy_o is high.
module owc_ctrl
    import owc_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int SEL_W  = 5,
    parameter int WAIT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [SEL_W-1:0]  pin_sel_i,
    input  logic [VAR_W-1:0]  variant_i,
    input  logic [WAIT_W-1:0] settle_cycles_i,
    output logic              conv_start_o,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic              exc_en_o,
    output logic [SEL_W-1:0]  exc_sel_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              open_o,
    output logic [DATA_W-1:0] delta_o,
    output logic              sel_err_o
);

    logic              tmr_load;
    logic [WAIT_W-1:0] tmr_val;
    logic              tmr_run;
    logic              tmr_zero;
    logic [DATA_W-1:0] base_code;
    logic [VAR_W-1:0]  var_code;
    logic [DATA_W-1:0] jdg_delta;
    logic              jdg_open;

    owc_seq #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .WAIT_W(WAIT_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .abort_i(abort_i),
        .pin_sel_i(pin_sel_i), .variant_i(variant_i), .settle_i(settle_cycles_i),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .tmr_zero_i(tmr_zero), .jdg_delta_i(jdg_delta), .jdg_open_i(jdg_open),
        .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .tmr_run_o(tmr_run),
        .base_o(base_code), .variant_o(var_code),
        .conv_start_o(conv_start_o), .exc_en_o(exc_en_o), .exc_sel_o(exc_sel_o),
        .busy_o(busy_o), .done_o(done_o), .open_o(open_o), .delta_o(delta_o),
        .sel_err_o(sel_err_o)
    );

    owc_settle_timer #(.WAIT_W(WAIT_W)) tmr_i (
        .clk(clk), .rst_n(rst_n),
        .load_i(tmr_load), .load_val_i(tmr_val), .run_i(tmr_run),
        .zero_o(tmr_zero)
    );

    owc_judge #(.DATA_W(DATA_W)) judge_i (
        .base_i(base_code), .sample_i(conv_data_i), .variant_i(var_code),
        .delta_o(jdg_delta), .open_o(jdg_open)
    );

endmodule

// File: rtl/owc_ctrl_chk.sv
`timescale 1ns/1ps
// Assertion checker for owc_ctrl, attached by bind. It observes only the
// ports of the top and keeps its own settling counters.
module owc_ctrl_chk #(
    parameter int DATA_W = 24,
    parameter int SEL_W  = 5,
    parameter int WAIT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              abort_i,
    input logic [SEL_W-1:0]  pin_sel_i,
    input logic [WAIT_W-1:0] settle_cycles_i,
    input logic              conv_start_o,
    input logic              exc_en_o,
    input logic [SEL_W-1:0]  exc_sel_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              open_o,
    input logic [DATA_W-1:0] delta_o
);

    logic [WAIT_W-1:0] set_lat;
    logic [WAIT_W:0]   on_cnt;
    logic [WAIT_W:0]   off_cnt;
    logic              accept;

    assign accept = start_i && !busy_o && !abort_i && !pin_sel_i[SEL_W-1];

    // Latch the settling time of the accepted check.
    always_ff @(posedge clk) begin
        if (!rst_n)      set_lat <= '0;
        else if (accept) set_lat <= settle_cycles_i;
    end

    // Count cycles spent with the current on and with it off (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_cnt  <= '0;
            off_cnt <= '0;
        end else begin
            on_cnt  <= exc_en_o ? ((&on_cnt) ? on_cnt : on_cnt + 1'b1) : '0;
            off_cnt <= exc_en_o ? '0 : ((&off_cnt) ? off_cnt : off_cnt + 1'b1);
        end
    end

    // R2: conversion request lasts one cycle
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    // R3: measurement waits for the on-settling time
    a_r3_settle_on: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start_o && exc_en_o) |-> (on_cnt >= {1'b0, set_lat}));

    // R4: done waits for the off-settling time
    a_r4_settle_off: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!exc_en_o && (off_cnt >= {1'b0, set_lat})));

    // R7: invalid pin code never excites or starts
    a_r7_bad_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !abort_i && pin_sel_i[SEL_W-1]) |=> (!busy_o && !exc_en_o));

    // R8: start while busy leaves the pin unchanged
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(exc_sel_o));

    // R9: abort returns to idle with the current off
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !exc_en_o && !done_o));

    // R10: done is a single-cycle pulse at the end of busy
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R10: results move only with done
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(delta_o) && $stable(open_o)));

endmodule

bind owc_ctrl owc_ctrl_chk #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .WAIT_W(WAIT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .pin_sel_i(pin_sel_i), .settle_cycles_i(settle_cycles_i),
    .conv_start_o(conv_start_o), .exc_en_o(exc_en_o), .exc_sel_o(exc_sel_o),
    .busy_o(busy_o), .done_o(done_o), .open_o(open_o), .delta_o(delta_o)
);

// File: tb/owc_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for owc_ctrl with a simple converter model.
module owc_ctrl_tb_top;

    localparam int  LAT = 3;
    localparam longint FS = 8388607;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        abort_i = 1'b0;
    logic [4:0]  pin_sel_i = '0;
    logic [1:0]  variant_i = '0;
    logic [31:0] settle_cycles_i = '0;
    logic        conv_start_o;
    logic        conv_done_i;
    logic [23:0] conv_data_i;
    logic        exc_en_o;
    logic [4:0]  exc_sel_o;
    logic        busy_o;
    logic        done_o;
    logic        open_o;
    logic [23:0] delta_o;
    logic        sel_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    longint base_val = 0;
    longint meas_val = 0;
    int     conv_cnt = 0;
    bit     exc_first = 0;
    bit     exc_second = 0;
    int     pend = 0;
    longint last_delta = 0;
    bit     last_open = 0;

    always #4 clk = ~clk;

    owc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .pin_sel_i(pin_sel_i), .variant_i(variant_i),
        .settle_cycles_i(settle_cycles_i), .conv_start_o(conv_start_o),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .exc_en_o(exc_en_o), .exc_sel_o(exc_sel_o), .busy_o(busy_o),
        .done_o(done_o), .open_o(open_o), .delta_o(delta_o), .sel_err_o(sel_err_o)
    );

    // Converter model: answers each request after LAT cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            conv_done_i <= 1'b0;
            conv_data_i <= '0;
            pend        <= 0;
        end else begin
            conv_done_i <= 1'b0;
            if (pend == 1) begin
                conv_done_i <= 1'b1;
                conv_data_i <= exc_second && conv_cnt >= 2 ? meas_val[23:0] : base_val[23:0];
            end
            if (pend > 0) pend <= pend - 1;
            if (conv_start_o) begin
                pend <= LAT;
                if (conv_cnt == 0) exc_first  <= exc_en_o;
                if (conv_cnt == 1) exc_second <= exc_en_o;
                conv_cnt <= conv_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint thr_of(input int v);
        longint pm;
        pm = (v == 0) ? 174 : (v == 1) ? 238 : 244;
        return (pm * FS) / 1000;
    endfunction

    function automatic longint sat(input longint d);
        if (d > FS) return FS;
        if (d < -FS - 1) return -FS - 1;
        return d;
    endfunction

    // Full check run with expected results derived from R5 and R6.
    task automatic run_check(input logic [4:0] sel, input logic [1:0] v,
                             input int settle, input longint b, input longint m,
                             input string tag);
        longint exp_d;
        bit     exp_o;
        int     on_n = 0;
        int     off_n = 0;
        bit     meas_seen = 0;
        bit     got = 0;
        exp_d = sat(m - b);
        exp_o = exp_d > thr_of(int'(v));
        @(negedge clk);
        base_val = b; meas_val = m; conv_cnt = 0; exc_first = 0; exc_second = 0;
        pin_sel_i = sel; variant_i = v; settle_cycles_i = settle; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10", {tag, " busy after start"}, busy_o, 1);
        for (int i = 0; i < 3000 && !got; i++) begin
            if (conv_start_o && exc_en_o) meas_seen = 1;
            else if (exc_en_o && !meas_seen) on_n++;
            else if (meas_seen && busy_o && !exc_en_o) off_n++;
            if (done_o) got = 1;
            else @(negedge clk);
        end
        chk(got, "R10", {tag, " done seen"}, got, 1);
        chk(!busy_o, "R10", {tag, " idle at done"}, busy_o, 0);
        chk(conv_cnt == 2, "R2", {tag, " conversion count"}, conv_cnt, 2);
        chk(!exc_first && exc_second, "R2", {tag, " excitation per conversion"},
            {exc_first, exc_second}, 1);
        chk(on_n >= settle, "R3", {tag, " on settle cycles"}, on_n, settle);
        chk(off_n >= settle, "R4", {tag, " off settle cycles"}, off_n, settle);
        chk(longint'($signed(delta_o)) == exp_d, "R5", {tag, " delta"},
            longint'($signed(delta_o)), exp_d);
        chk(open_o == exp_o, "R6", {tag, " open flag"}, open_o, exp_o);
        chk(exc_sel_o == sel, "R11", {tag, " pin select"}, exc_sel_o, sel);
        last_delta = exp_d; last_open = exp_o;
        @(negedge clk);
        chk(!done_o, "R10", {tag, " done one cycle"}, done_o, 0);
    endtask

    task automatic t_reset;
        chk(!busy_o && !exc_en_o && !conv_start_o && !done_o && !open_o && !sel_err_o,
            "R1", "control outputs at reset",
            {busy_o, exc_en_o, conv_start_o, done_o, open_o, sel_err_o}, 0);
        chk(delta_o == 0 && exc_sel_o == 0, "R1", "data outputs at reset",
            delta_o, 0);
    endtask

    task automatic t_bad_pin;
        logic [4:0] keep;
        bit moved = 0;
        keep = exc_sel_o;
        @(negedge clk);
        conv_cnt = 0; pin_sel_i = 5'b10011; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(sel_err_o, "R7", "error flag raised", sel_err_o, 1);
        for (int i = 0; i < 20; i++) begin
            if (busy_o || exc_en_o || conv_start_o) moved = 1;
            @(negedge clk);
        end
        chk(!moved, "R7", "no activity on invalid pin", moved, 0);
        chk(conv_cnt == 0, "R7", "no conversions", conv_cnt, 0);
        chk(exc_sel_o == keep, "R7", "pin select kept", exc_sel_o, keep);
        chk(sel_err_o, "R7", "error flag held", sel_err_o, 1);
        run_check(5'd2, 2'd1, 5, 0, 100, "R7 recover");
        chk(!sel_err_o, "R7", "error flag cleared by valid start", sel_err_o, 0);
    endtask

    task automatic t_busy_start;
        int dn = 0;
        @(negedge clk);
        conv_cnt = 0; base_val = 0; meas_val = 5000;
        pin_sel_i = 5'd4; variant_i = 2'd1; settle_cycles_i = 5; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        pin_sel_i = 5'd9; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done_o) dn++;
            @(negedge clk);
        end
        chk(dn == 1, "R8", "single done", dn, 1);
        chk(conv_cnt == 2, "R8", "no extra conversion", conv_cnt, 2);
        chk(exc_sel_o == 5'd4, "R8", "pin kept", exc_sel_o, 4);
        last_delta = 5000; last_open = 0;
    endtask

    task automatic t_abort;
        bit dn = 0;
        @(negedge clk);
        base_val = 0; meas_val = 7000000;
        pin_sel_i = 5'd6; variant_i = 2'd0; settle_cycles_i = 50; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 100 && !exc_en_o; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exc_en_o, "R9", "excitation on before abort", exc_en_o, 1);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(!exc_en_o && !busy_o, "R9", "idle after abort", {exc_en_o, busy_o}, 0);
        for (int i = 0; i < 150; i++) begin
            if (done_o) dn = 1;
            @(negedge clk);
        end
        chk(!dn, "R9", "no done after abort", dn, 0);
        chk(longint'($signed(delta_o)) == last_delta && open_o == last_open, "R9",
            "results kept", longint'($signed(delta_o)), last_delta);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        run_check(5'd1, 2'd1, 5, 100000, 100000 + 1887436, "R6 v20 connected");
        run_check(5'd3, 2'd1, 5, 100000, 100000 + 2097151, "R6 v20 open");
        run_check(5'd5, 2'd0, 0, 0, thr_of(0), "R6 v12 at threshold");
        run_check(5'd5, 2'd0, 0, 0, thr_of(0) + 1, "R6 v12 above threshold");
        run_check(5'd7, 2'd2, 200, -1000, -1000 + thr_of(2) - 5, "R6 v40 connected");
        run_check(5'd15, 2'd3, 5, 0, thr_of(3) + 1, "R6 v3 open");
        run_check(5'd0, 2'd1, 5, -8388000, 8388000, "R5 positive saturation");
        run_check(5'd8, 2'd1, 5, 8000000, -8000000, "R5 negative saturation");
        t_bad_pin();
        t_busy_start();
        t_abort();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule